// File: doc/BRIEF.md
# Flash Chip-Erase Command Decoder

This block is the write-side command front end of a word-addressed NOR-style flash with a 16-bit data bus. It watches single-cycle bus writes for the six-write unlock pattern that requests a full-array erase. When the pattern matches, it starts an embedded erase engine. The engine first clears every word to zero, one word per clock in ascending order. It then waits out a fixed erase interval and sets the whole array to FFFFh in one step. The array is a small behavioural memory.

While the engine runs, reads return a status word instead of array data, and every bus write is ignored. A separate active-low hardware reset input stops the engine at once. The words it had already cleared stay zero, the words it had not reached keep their old contents, and the command matcher goes back to its first step. The host then reissues the whole sequence. The power-on reset loads the array with a known seed pattern.

Top module: `flash_erase_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `busy` and `rdata` to 0 and loads array word i with SEED_WORD XOR i (default SEED_WORD = 3C00h). `rst_n` is sampled synchronously.
- R2: When `busy` is low and `re` is high at a rising edge, `rdata` takes, at that edge, the array word selected by the low ARRAY_AW bits of `addr`. The upper address bits are ignored on reads.
- R3: The erase command is six writes, in order: AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, 10h at 555h. The full `addr` is compared, along with `wdata[7:0]`; `wdata[15:8]` is ignored. `busy` rises at the second rising edge after the sixth write is sampled.
- R4: A write whose address or low data byte does not match the current step sends the matcher back to step one. This includes F0h. A later partial sequence then starts no erase, and the array is left unchanged.
- R5: After a completed sequence, `busy` stays high for exactly 2^ARRAY_AW + ERASE_CYCLES clock cycles.
- R6: A read while `busy` is high returns a status word. Bit 7 is 0. Bits 6 and 2 are equal, are 0 on the first read of an erase, and invert on each later read of that erase. All other bits are 0. So the reads alternate 0000h and 0044h.
- R7: Writes while `busy` is high are ignored. This covers the suspend code B0h, F0h and a complete six-write sequence. The busy period keeps its length, and no second erase follows it.
- R8: When the busy period ends normally, every array word reads FFFFh and reads return array data again.
- R9: During the first 2^ARRAY_AW busy cycles, the engine zeroes word k in busy cycle k+1. Word 0 is cleared in the first busy cycle.
- R10: `hw_rst_n` low at a rising edge drops `busy` at that edge. Words not yet zeroed keep their values, no fill happens afterwards, and a fresh six-write sequence starts a full erase again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low power-on reset; loads the seed pattern |
| hw_rst_n | input | 1 | Synchronous active-low hardware reset; aborts an erase, leaves the array alone |
| we | input | 1 | Bus write strobe, one cycle per write |
| re | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W (11) | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data or status word |
| busy | output | 1 | High while the embedded erase runs |

## Verification
A read result lands in `rdata` at the same edge that samples `re`. The bench drives strobes on falling edges and a monitor pops the expected word at the next falling edge. `busy` is checked low one falling edge after the sixth write and high at the following one. Its high time is counted on falling edges and compared with 2^ARRAY_AW + ERASE_CYCLES. For the abort, the hardware reset is timed to the fifth edge after the sequence, so exactly words 0 to 2 must read zero while every later word keeps its seed value.

// File: rtl/flash_erase_pkg.sv
// Shared types and the command step table for the chip-erase decoder.
// Assumes word addresses of at least 11 bits and byte-wide command codes.
package flash_erase_pkg;

    localparam int CMD_STEPS = 6;
    localparam int CMD_AW    = 11;

    typedef struct packed {
        logic [CMD_AW-1:0] addr;
        logic [7:0]        code;
    } cmd_step_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_PREP  = 2'd1,
        ENG_ERASE = 2'd2
    } eng_state_e;

    // Bit positions of the status word returned while busy
    localparam int ST_DONE_BIT = 7;
    localparam int ST_TGL_A    = 6;
    localparam int ST_TGL_B    = 2;

    // Expected address and code for each step of the erase sequence
    function automatic cmd_step_t step_expect(input logic [2:0] idx);
        cmd_step_t s;
        case (idx)
            3'd0: s = '{addr: 11'h555, code: 8'hAA};
            3'd1: s = '{addr: 11'h2AA, code: 8'h55};
            3'd2: s = '{addr: 11'h555, code: 8'h80};
            3'd3: s = '{addr: 11'h555, code: 8'hAA};
            3'd4: s = '{addr: 11'h2AA, code: 8'h55};
            default: s = '{addr: 11'h555, code: 8'h10};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/flash_cmd_matcher.sv
// Command sequence matcher: follows bus writes through the six-step erase
// pattern and emits a one-cycle start pulse after the last step.
// Assumes ADDR_W >= 11; writes are ignored while the engine is busy.
module flash_cmd_matcher
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              busy,
    output logic              start,
    output logic [2:0]        step
);
    localparam logic [2:0] LAST_STEP = 3'(CMD_STEPS - 1);

    cmd_step_t exp_s;
    logic      hit;

    // Compare the current write against the expected step
    always_comb begin
        exp_s = step_expect(step);
        hit   = (addr == ADDR_W'(exp_s.addr)) && (wdata[7:0] == exp_s.code);
    end

    // Advance on a hit, fall back to step one on any other write
    always_ff @(posedge clk) begin
        if (!rst_n || !hw_rst_n) begin
            step  <= '0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (we && !busy) begin
                if (hit && step == LAST_STEP) begin
                    step  <= '0;
                    start <= 1'b1;
                end else if (hit) begin
                    step <= step + 3'd1;
                end else begin
                    step <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/flash_erase_engine.sv
// Embedded erase engine: zeroes the array word by word, waits a fixed
// erase interval, then requests a bulk fill to all ones.
// Assumes ERASE_CYCLES >= 1; the hardware reset aborts without a fill.
module flash_erase_engine
    import flash_erase_pkg::*;
#(
    parameter int ARRAY_AW     = 4,
    parameter int ERASE_CYCLES = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_rst_n,
    input  logic                start,
    output logic                busy,
    output logic                zero_we,
    output logic [ARRAY_AW-1:0] zero_idx,
    output logic                fill_all
);
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
    localparam logic [ARRAY_AW-1:0] LAST_IDX = '1;
    localparam logic [CNT_W-1:0]    CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);

    eng_state_e          state;
    logic [ARRAY_AW-1:0] ptr;
    logic [CNT_W-1:0]    cnt;

    // Array write requests, suppressed on the abort edge
    always_comb begin
        busy     = (state != ENG_IDLE);
        zero_we  = (state == ENG_PREP) && hw_rst_n;
        zero_idx = ptr;
        fill_all = (state == ENG_ERASE) && (cnt == '0) && hw_rst_n;
    end

    // Phase sequencing: idle -> pre-program sweep -> erase wait -> idle
    always_ff @(posedge clk) begin
        if (!rst_n || !hw_rst_n) begin
            state <= ENG_IDLE;
            ptr   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state <= ENG_PREP;
                        ptr   <= '0;
                    end
                end
                ENG_PREP: begin
                    if (ptr == LAST_IDX) begin
                        state <= ENG_ERASE;
                        cnt   <= CNT_LOAD;
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ENG_ERASE: begin
                    if (cnt == '0) state <= ENG_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_word_array.sv
// Behavioural word array with registered read port. Returns the status
// word instead of data while busy; the toggle bits flip on each busy read.
// Assumes a small depth (one register per word).
module flash_word_array
    import flash_erase_pkg::*;
#(
    parameter int          ADDR_W    = 11,
    parameter int          ARRAY_AW  = 4,
    parameter logic [15:0] SEED_WORD = 16'h3C00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hw_rst_n,
    input  logic                re,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                busy,
    input  logic                zero_we,
    input  logic [ARRAY_AW-1:0] zero_idx,
    input  logic                fill_all,
    output logic [15:0]         rdata
);
    localparam int DEPTH = 1 << ARRAY_AW;

    logic [15:0] words [DEPTH];
    logic        tgl;
    logic [15:0] status_w;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Per-word storage: seed on power-on reset, zero or fill on request
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= SEED_WORD ^ 16'(g);
            else if (fill_all)
                words[g] <= 16'hFFFF;
            else if (zero_we && zero_idx == ARRAY_AW'(g))
                words[g] <= 16'h0000;
        end
    end

    // Status word presented while the engine runs
    always_comb begin
        status_w               = 16'h0000;
        status_w[ST_DONE_BIT]  = 1'b0;
        status_w[ST_TGL_A]     = tgl;
        status_w[ST_TGL_B]     = tgl;
    end

    // Read register and toggle state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 16'h0000;
            tgl   <= 1'b0;
        end else begin
            if (re) rdata <= busy ? status_w : words[addr[ARRAY_AW-1:0]];
            if (!hw_rst_n || !busy) tgl <= 1'b0;
            else if (re)            tgl <= ~tgl;
        end
    end

endmodule

// File: rtl/flash_erase_ctrl.sv
// Top of the chip-erase command decoder: matcher, erase engine and array.
// Assumes ADDR_W >= 11 so that the command addresses fit.
module flash_erase_ctrl #(
    parameter int          ADDR_W       = 11,
    parameter int          ARRAY_AW     = 4,
    parameter int          ERASE_CYCLES = 40,
    parameter logic [15:0] SEED_WORD    = 16'h3C00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              busy
);
    localparam int BUSY_TOTAL = (1 << ARRAY_AW) + ERASE_CYCLES;

    logic                erase_start;
    logic [2:0]          cmd_step;
    logic                zero_we;
    logic [ARRAY_AW-1:0] zero_idx;
    logic                fill_all;

    flash_cmd_matcher #(.ADDR_W(ADDR_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_rst_n (hw_rst_n),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .busy     (busy),
        .start    (erase_start),
        .step     (cmd_step)
    );

    flash_erase_engine #(.ARRAY_AW(ARRAY_AW), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_rst_n (hw_rst_n),
        .start    (erase_start),
        .busy     (busy),
        .zero_we  (zero_we),
        .zero_idx (zero_idx),
        .fill_all (fill_all)
    );

    flash_word_array #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .SEED_WORD(SEED_WORD)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_rst_n (hw_rst_n),
        .re       (re),
        .addr     (addr),
        .busy     (busy),
        .zero_we  (zero_we),
        .zero_idx (zero_idx),
        .fill_all (fill_all),
        .rdata    (rdata)
    );

endmodule

// File: rtl/flash_erase_ctrl_chk.sv
// Protocol checker for the chip-erase decoder, bound to the top module.
// Assumes TOTAL is the nominal busy length of a completed erase.
module flash_erase_ctrl_chk #(
    parameter int TOTAL = 56
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hw_rst_n,
    input logic        we,
    input logic        re,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        busy,
    input logic        erase_start,
    input logic [2:0]  cmd_step
);
    localparam int LEN_W = $clog2(TOTAL + 1) + 1;

    logic [LEN_W-1:0] busy_len;

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start && hw_rst_n |=> busy);

    p_f0_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we && !busy && wdata[7:0] == 8'hF0 |=> cmd_step == 3'd0);

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(hw_rst_n) |-> busy_len == LEN_W'(TOTAL));

    p_status_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        re && busy |=> rdata[15:7] == '0 && rdata[5:3] == '0
                       && rdata[1:0] == '0 && rdata[6] == rdata[2]);

    p_status_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (re && busy && hw_rst_n) ##1 (re && busy) |=> rdata[6] != $past(rdata[6]));

    p_no_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !erase_start);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> !busy);

endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(.TOTAL(BUSY_TOTAL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_rst_n    (hw_rst_n),
    .we          (we),
    .re          (re),
    .wdata       (wdata),
    .rdata       (rdata),
    .busy        (busy),
    .erase_start (erase_start),
    .cmd_step    (cmd_step)
);

// File: tb/flash_erase_ctrl_test.sv
// Scoreboard bench for the chip-erase decoder.
module flash_erase_ctrl_test;
    localparam int          DEPTH = 16;
    localparam int          EC    = 40;
    localparam int          TOTAL = DEPTH + EC;
    localparam logic [15:0] SEED  = 16'h3C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_rst_n = 1'b1;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [10:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int errors = 0;
    int checks = 0;
    int run = 0;
    int last_run = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [10:0] seq_a [6];
    logic [15:0] seq_d [6];

    flash_erase_ctrl uut (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .we(we), .re(re),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    // Driver: issue a read and queue the expected word
    task automatic bus_read(input logic [10:0] a, input logic [15:0] e, input string tag);
        @(negedge clk); re = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); re = 1'b0;
    endtask

    // Six-write sequence; step rs (0..5) replaced by ra/rd, rs<0 for none
    task automatic send_seq(input int rs, input logic [10:0] ra, input logic [15:0] rd);
        for (int i = 0; i < 6; i++) begin
            if (i == rs) bus_write(ra, rd);
            else         bus_write(seq_a[i], seq_d[i]);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic power_reset();
        @(negedge clk); rst_n = 1'b0;
        idle_cycles(3);
        rst_n = 1'b1;
    endtask

    // Monitor: compare each read result one edge after it was sampled
    initial begin
        forever begin
            @(posedge clk);
            if (re) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL unexpected read actual=%h expected=none", rdata);
                end else begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    // Busy run length measured on falling edges
    always @(negedge clk) begin
        if (busy) run++;
        else begin
            if (run != 0) last_run = run;
            run = 0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        seq_a[0] = 11'h555; seq_d[0] = 16'h00AA;
        seq_a[1] = 11'h2AA; seq_d[1] = 16'h0055;
        seq_a[2] = 11'h555; seq_d[2] = 16'h0080;
        seq_a[3] = 11'h555; seq_d[3] = 16'h00AA;
        seq_a[4] = 11'h2AA; seq_d[4] = 16'h0055;
        seq_a[5] = 11'h555; seq_d[5] = 16'h0010;

        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {15'd0, busy}, 16'h0000);
        check("R1 rdata after reset", rdata, 16'h0000);
        bus_read(11'h000, SEED ^ 16'd0, "R1 seed word 0");
        bus_read(11'h005, SEED ^ 16'd5, "R1 seed word 5");
        bus_read(11'h00F, SEED ^ 16'd15, "R2 read word 15");
        bus_read(11'h7F3, SEED ^ 16'd3, "R2 upper address bits ignored");

        // Mismatches: no erase may start
        send_seq(5, 11'h555, 16'h0020);
        idle_cycles(4);
        check("R4 wrong final code", {15'd0, busy}, 16'h0000);
        send_seq(2, 11'h555, 16'h00F0);
        idle_cycles(4);
        check("R4 F0 mid-sequence", {15'd0, busy}, 16'h0000);
        send_seq(1, 11'h2AB, 16'h0055);
        idle_cycles(4);
        check("R4 wrong address", {15'd0, busy}, 16'h0000);
        bus_read(11'h004, SEED ^ 16'd4, "R4 array untouched");

        // Full erase, upper byte of one step set
        send_seq(0, 11'h555, 16'h12AA);
        check("R3 busy not yet up", {15'd0, busy}, 16'h0000);
        @(negedge clk);
        check("R3 busy up", {15'd0, busy}, 16'h0001);
        bus_read(11'h001, 16'h0000, "R6 first status read");
        bus_read(11'h001, 16'h0044, "R6 second status read");
        bus_read(11'h002, 16'h0000, "R6 third status read");
        bus_write(11'h555, 16'h00B0);
        bus_write(11'h000, 16'h00F0);
        send_seq(-1, 11'h0, 16'h0);
        wait_idle();
        @(negedge clk);
        check("R5 busy length", 16'(last_run), 16'(TOTAL));
        check("R7 length unchanged by writes", 16'(last_run), 16'(TOTAL));
        idle_cycles(10);
        check("R7 no second erase", {15'd0, busy}, 16'h0000);
        for (int i = 0; i < DEPTH; i++)
            bus_read(11'(i), 16'hFFFF, "R8 word erased");

        // Hardware reset abort during pre-program sweep
        power_reset();
        send_seq(-1, 11'h0, 16'h0);
        @(negedge clk);
        check("R3 busy up again", {15'd0, busy}, 16'h0001);
        idle_cycles(3);
        hw_rst_n = 1'b0;
        @(negedge clk);
        hw_rst_n = 1'b1;
        check("R10 busy dropped at once", {15'd0, busy}, 16'h0000);
        bus_read(11'h000, 16'h0000, "R9 word 0 zeroed");
        bus_read(11'h002, 16'h0000, "R9 word 2 zeroed");
        bus_read(11'h003, SEED ^ 16'd3, "R9 word 3 not reached");
        bus_read(11'h00F, SEED ^ 16'd15, "R10 no fill after abort");
        idle_cycles(60);
        check("R10 stays idle", {15'd0, busy}, 16'h0000);
        bus_read(11'h009, SEED ^ 16'd9, "R10 array kept");
        send_seq(-1, 11'h0, 16'h0);
        @(negedge clk);
        check("R10 reissued sequence starts", {15'd0, busy}, 16'h0001);
        wait_idle();
        @(negedge clk);
        check("R10 full length after reissue", 16'(last_run), 16'(TOTAL));
        bus_read(11'h009, 16'hFFFF, "R10 erased after reissue");

        idle_cycles(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule